// File: doc/BRIEF.md
# Nibble Arithmetic and Rotate Unit with Carry, Zero and Status Flags

This block is the arithmetic core of a small 4-bit controller. It takes the accumulator value and a second operand, applies one of eight operations, and keeps a result register together with three flags. The operations are add, add with carry, subtract, compare, rotate left and rotate right through carry, and two carry-test operations. The carry-test operations move the carry into the status flag and then force the carry to a fixed value.

On subtraction and compare, the carry flag is an inverted borrow: 1 means the second operand was not larger than the accumulator. The status flag is the flag that the controller's conditional branches test. Arithmetic operations load it with the new carry. The carry-test operations load it with the old carry. Nothing in the block changes state unless the update strobe is high at a clock edge. The data width is a parameter, and the requirements below are stated for the default width of 4.

Top module: `nalu_core`

## Requirements
- R1: While reset is low, the result reads 0, the carry and zero flags read 0, and the status flag reads 1.
- R2: On a clock edge with the update strobe low, the result and all three flags keep their values, whatever the operation code and operands are.
- R3: Op code 0 (add) stores (acc + opnd) mod 16 and sets carry to the carry out of bit 3. Op code 1 (add with carry) also adds the old carry into bit 0.
- R4: Op code 2 (subtract) stores (acc − opnd) mod 16. It sets carry to 1 when acc ≥ opnd and to 0 when a borrow occurs.
- R5: Op code 3 (compare) sets carry, zero and status exactly as op code 2 would, and leaves the result register unchanged.
- R6: For op codes 0 to 5, zero becomes 1 when the computed value is 0 and becomes 0 otherwise. For compare, the computed value is the difference. Op codes 6 and 7 leave zero unchanged.
- R7: Op code 4 (rotate left) stores {acc[2:0], old carry} and sets carry to acc[3].
- R8: Op code 5 (rotate right) stores {old carry, acc[3:1]} and sets carry to acc[0].
- R9: After op codes 0 to 3, status equals the new carry. Op codes 4 and 5 leave status unchanged.
- R10: Op code 6 copies the old carry into status and clears carry. Op code 7 copies the old carry into status and sets carry. Both leave the result register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_en | input | 1 | Update strobe; state changes only when high |
| op_in | input | 3 | Operation code 0..7 |
| acc_in | input | 4 | Accumulator operand |
| opnd_in | input | 4 | Second operand |
| res_out | output | 4 | Registered result |
| cf_out | output | 1 | Carry flag |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Status flag |

## Verification
The properties assume that the operation code and both operands are known and steady around every clock edge. They also assume that reset is held for at least one edge before the first update. The bench meets these assumptions by driving every input only on the falling edge and by starting all stimulus only after a reset phase of several cycles. The sweep covers every operation code, every pair of operands, and both values of the incoming carry. The incoming carry is forced beforehand with the carry-test operations. After each update, an idle cycle with the strobe low is driven with different inputs, which probes the hold behaviour.

// File: rtl/nalu_pkg.sv
// Package for the nibble ALU: operation encoding and shared width default.
// Assumes the op code field is three bits wide; all eight codes are used.
package nalu_pkg;
    localparam int unsigned DATA_W = 4;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADC  = 3'd1,
        OP_SUB  = 3'd2,
        OP_CMP  = 3'd3,
        OP_ROL  = 3'd4,
        OP_ROR  = 3'd5,
        OP_TSTC = 3'd6,
        OP_TSTS = 3'd7
    } alu_op_e;
endpackage

// File: rtl/nalu_adder.sv
// Adder/subtractor for the nibble ALU.
// Does: a + b + cin, or a + ~b + 1 when sub is high, so that the carry out
// directly gives the "no borrow" carry convention. Assumes W >= 1.
module nalu_adder #(
    parameter int unsigned W = nalu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout
);
    localparam int unsigned EW = W + 1;

    logic [W-1:0]  b_eff;
    logic          c_eff;
    logic [EW-1:0] total;

    // Select operand inversion and forced carry-in for subtraction.
    always_comb begin
        b_eff = sub ? ~b : b;
        c_eff = sub ? 1'b1 : cin;
    end

    // Single ripple sum with carry out in the extra bit.
    always_comb begin
        total = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        sum   = total[W-1:0];
        cout  = total[W];
    end
endmodule

// File: rtl/nalu_rotator.sv
// Rotate-through-carry unit for the nibble ALU.
// Does: left rotate puts cin in the LSB and returns the old MSB; right rotate
// puts cin in the MSB and returns the old LSB. Assumes W >= 2.
module nalu_rotator #(
    parameter int unsigned W = nalu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic         left,
    output logic [W-1:0] q,
    output logic         cout
);
    logic [W-1:0] q_l;
    logic [W-1:0] q_r;

    // Build both rotate results bit by bit.
    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign q_l[i] = cin;
            assign q_r[i] = a[i+1];
        end else if (i == W - 1) begin : g_msb
            assign q_l[i] = a[i-1];
            assign q_r[i] = cin;
        end else begin : g_mid
            assign q_l[i] = a[i-1];
            assign q_r[i] = a[i+1];
        end
    end

    // Pick the direction and the bit shifted out.
    always_comb begin
        q    = left ? q_l : q_r;
        cout = left ? a[W-1] : a[0];
    end
endmodule

// File: rtl/nalu_state.sv
// State registers for the nibble ALU: result, carry, zero and status.
// Does: each register loads its next value when upd_en and its own write
// enable are both high. Assumes synchronous active-low reset; status resets to 1.
module nalu_state #(
    parameter int unsigned W = nalu_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic         wr_res,
    input  logic [W-1:0] nxt_res,
    input  logic         wr_cf,
    input  logic         nxt_cf,
    input  logic         wr_zf,
    input  logic         nxt_zf,
    input  logic         wr_sf,
    input  logic         nxt_sf,
    output logic [W-1:0] res_q,
    output logic         cf_q,
    output logic         zf_q,
    output logic         sf_q
);
    // Result register.
    always_ff @(posedge clk) begin
        if (!rst_n)                res_q <= '0;
        else if (upd_en && wr_res) res_q <= nxt_res;
    end

    // Carry flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)               cf_q <= 1'b0;
        else if (upd_en && wr_cf) cf_q <= nxt_cf;
    end

    // Zero flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)               zf_q <= 1'b0;
        else if (upd_en && wr_zf) zf_q <= nxt_zf;
    end

    // Status flag register, set on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)               sf_q <= 1'b1;
        else if (upd_en && wr_sf) sf_q <= nxt_sf;
    end
endmodule

// File: rtl/nalu_core.sv
// Top of the nibble ALU.
// Does: decodes the op code, steers operands to the adder or the rotator,
// and sets the per-register write enables for the state block.
// Assumes operands are stable around the clock edge when upd_en is high.
module nalu_core #(
    parameter int unsigned W = nalu_pkg::DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic [2:0]   op_in,
    input  logic [W-1:0] acc_in,
    input  logic [W-1:0] opnd_in,
    output logic [W-1:0] res_out,
    output logic         cf_out,
    output logic         zf_out,
    output logic         sf_out
);
    import nalu_pkg::*;

    alu_op_e      op;
    logic         is_sub;
    logic         add_cin;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         rot_left;
    logic [W-1:0] rot_q;
    logic         rot_cout;
    logic         wr_res, wr_cf, wr_zf, wr_sf;
    logic [W-1:0] nxt_res;
    logic         nxt_cf, nxt_zf, nxt_sf;
    logic [W-1:0] res_q;
    logic         cf_q, zf_q, sf_q;

    assign op = alu_op_e'(op_in);

    // Operand steering for the two datapath units.
    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_CMP);
        add_cin  = (op == OP_ADC) ? cf_q : 1'b0;
        rot_left = (op == OP_ROL);
    end

    nalu_adder #(.W(W)) u_add (
        .a    (acc_in),
        .b    (opnd_in),
        .cin  (add_cin),
        .sub  (is_sub),
        .sum  (add_sum),
        .cout (add_cout)
    );

    nalu_rotator #(.W(W)) u_rot (
        .a    (acc_in),
        .cin  (cf_q),
        .left (rot_left),
        .q    (rot_q),
        .cout (rot_cout)
    );

    // Next-state values and write enables per operation.
    always_comb begin
        wr_res  = 1'b0;
        wr_cf   = 1'b0;
        wr_zf   = 1'b0;
        wr_sf   = 1'b0;
        nxt_res = add_sum;
        nxt_cf  = add_cout;
        nxt_zf  = (add_sum == '0);
        nxt_sf  = add_cout;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB: begin
                wr_res = 1'b1;
                wr_cf  = 1'b1;
                wr_zf  = 1'b1;
                wr_sf  = 1'b1;
            end
            OP_CMP: begin
                wr_cf  = 1'b1;
                wr_zf  = 1'b1;
                wr_sf  = 1'b1;
            end
            OP_ROL, OP_ROR: begin
                wr_res  = 1'b1;
                wr_cf   = 1'b1;
                wr_zf   = 1'b1;
                nxt_res = rot_q;
                nxt_cf  = rot_cout;
                nxt_zf  = (rot_q == '0);
            end
            OP_TSTC, OP_TSTS: begin
                wr_cf  = 1'b1;
                wr_sf  = 1'b1;
                nxt_cf = (op == OP_TSTS);
                nxt_sf = cf_q;
            end
            default: ;
        endcase
    end

    nalu_state #(.W(W)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .wr_res  (wr_res),
        .nxt_res (nxt_res),
        .wr_cf   (wr_cf),
        .nxt_cf  (nxt_cf),
        .wr_zf   (wr_zf),
        .nxt_zf  (nxt_zf),
        .wr_sf   (wr_sf),
        .nxt_sf  (nxt_sf),
        .res_q   (res_q),
        .cf_q    (cf_q),
        .zf_q    (zf_q),
        .sf_q    (sf_q)
    );

    // Drive outputs from the state registers.
    always_comb begin
        res_out = res_q;
        cf_out  = cf_q;
        zf_out  = zf_q;
        sf_out  = sf_q;
    end
endmodule

// File: rtl/nalu_core_chk.sv
// Property checker for the nibble ALU, bound to nalu_core.
// Assumes inputs are known at every rising edge after reset.
module nalu_core_chk #(
    parameter int unsigned W = nalu_pkg::DATA_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         upd_en,
    input logic [2:0]   op_in,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] opnd_in,
    input logic [W-1:0] res_out,
    input logic         cf_out,
    input logic         zf_out,
    input logic         sf_out
);
    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_en |=> ($stable(res_out) && $stable(cf_out) && $stable(zf_out) && $stable(sf_out)));

    // R3
    add_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_in == 3'd0) |=>
            (cf_out == ((int'($past(acc_in)) + int'($past(opnd_in))) >= (1 << W))));

    // R4
    sub_borrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_in == 3'd2) |=> (cf_out == ($past(acc_in) >= $past(opnd_in))));

    // R5
    cmp_keeps_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_in == 3'd3) |=>
            ($stable(res_out) && cf_out == ($past(acc_in) >= $past(opnd_in))));

    // R6
    zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_in != 3'd3 && op_in <= 3'd5) |=> (zf_out == (res_out == '0)));

    // R9
    rot_keeps_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && (op_in == 3'd4 || op_in == 3'd5)) |=> $stable(sf_out));

    // R9
    arith_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_in <= 3'd3) |=> (sf_out == cf_out));

    // R10
    carry_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_en && op_in[2:1] == 2'b11) |=>
            (sf_out == $past(cf_out) && cf_out == $past(op_in[0]) && $stable(res_out) && $stable(zf_out)));
endmodule

bind nalu_core nalu_core_chk #(.W(W)) u_nalu_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .upd_en  (upd_en),
    .op_in   (op_in),
    .acc_in  (acc_in),
    .opnd_in (opnd_in),
    .res_out (res_out),
    .cf_out  (cf_out),
    .zf_out  (zf_out),
    .sf_out  (sf_out)
);

// File: tb/nalu_core_bench.sv
// Exhaustive bench for nalu_core at width 4: every op, operand pair and carry-in.
module nalu_core_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       upd_en;
    logic [2:0] op_in;
    logic [3:0] acc_in;
    logic [3:0] opnd_in;
    logic [3:0] res_out;
    logic       cf_out, zf_out, sf_out;

    int n_run  = 0;
    int n_fail = 0;

    logic [3:0] m_res;
    logic       m_cf, m_zf, m_sf;

    always #2 clk = ~clk;

    nalu_core #(.W(4)) u_nalu_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .upd_en  (upd_en),
        .op_in   (op_in),
        .acc_in  (acc_in),
        .opnd_in (opnd_in),
        .res_out (res_out),
        .cf_out  (cf_out),
        .zf_out  (zf_out),
        .sf_out  (sf_out)
    );

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Reference model applied to the model state.
    task automatic model(input logic [2:0] o, input logic [3:0] a, input logic [3:0] b);
        int t;
        logic oc;
        oc = m_cf;
        case (o)
            3'd0, 3'd1: begin
                t = int'(a) + int'(b) + ((o == 3'd1) ? int'(oc) : 0);
                m_res = 4'(t % 16);
                m_cf = (t > 15);
                m_zf = (t % 16 == 0);
                m_sf = m_cf;
            end
            3'd2, 3'd3: begin
                t = (int'(a) - int'(b) + 16) % 16;
                if (o == 3'd2) m_res = 4'(t);
                m_cf = (a >= b);
                m_zf = (t == 0);
                m_sf = m_cf;
            end
            3'd4: begin
                m_res = 4'((int'(a) * 2) % 16 + int'(oc));
                m_cf = (a >= 4'd8);
                m_zf = (m_res == 4'd0);
            end
            3'd5: begin
                m_res = 4'(int'(a) / 2 + (oc ? 8 : 0));
                m_cf = (a % 2 == 1);
                m_zf = (m_res == 4'd0);
            end
            default: begin
                m_sf = oc;
                m_cf = (o == 3'd7);
            end
        endcase
    endtask

    // Drive at a falling edge, let one rising edge pass, check at the next falling edge.
    task automatic step(input logic en, input logic [2:0] o, input logic [3:0] a, input logic [3:0] b);
        string tr, tc;
        upd_en = en; op_in = o; acc_in = a; opnd_in = b;
        if (en) model(o, a, b);
        @(negedge clk);
        if (!en) begin
            tr = "R2"; tc = "R2";
        end else begin
            case (o)
                3'd0, 3'd1: begin tr = "R3";  tc = "R3";  end
                3'd2:       begin tr = "R4";  tc = "R4";  end
                3'd3:       begin tr = "R5";  tc = "R5";  end
                3'd4:       begin tr = "R7";  tc = "R7";  end
                3'd5:       begin tr = "R8";  tc = "R8";  end
                default:    begin tr = "R10"; tc = "R10"; end
            endcase
        end
        chk(tr, "result", int'(res_out), int'(m_res));
        chk(tc, "carry", int'(cf_out), int'(m_cf));
        chk((!en) ? "R2" : (o >= 3'd6 ? "R10" : "R6"), "zero", int'(zf_out), int'(m_zf));
        chk((!en) ? "R2" : (o >= 3'd6 ? "R10" : "R9"), "status", int'(sf_out), int'(m_sf));
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run is a failure.
    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0; upd_en = 1'b1; op_in = 3'd0; acc_in = 4'hF; opnd_in = 4'hF;
        m_res = 4'd0; m_cf = 1'b0; m_zf = 1'b0; m_sf = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset values, checked while reset is still low
        chk("R1", "result", int'(res_out), 0);
        chk("R1", "carry",  int'(cf_out), 0);
        chk("R1", "zero",   int'(zf_out), 0);
        chk("R1", "status", int'(sf_out), 1);
        rst_n = 1'b1;
        for (int o = 0; o < 8; o++) begin
            for (int c = 0; c < 2; c++) begin
                for (int a = 0; a < 16; a++) begin
                    for (int b = 0; b < 16; b++) begin
                        step(1'b1, (c == 1) ? 3'd7 : 3'd6, 4'(b), 4'(a));
                        step(1'b1, 3'(o), 4'(a), 4'(b));
                        // R2 idle cycle with different inputs
                        step(1'b0, 3'(7 - o), 4'(~a), 4'(~b));
                    end
                end
            end
        end
        summary();
        $finish;
    end
endmodule